// File: doc/BRIEF.md
# Horizontal Line Sync Generator

This block times each horizontal line of a retro home-computer display. A counter runs without pause and repeats every 207 clocks. A fixed window of counts in each line is decoded as the horizontal sync pulse. The counts just after that window are decoded as a back-porch indication. The count itself is also brought out for any logic that needs the position within the line.

The CPU can resynchronise the line. When it acknowledges an interrupt, the counter restarts at the beginning of the line. A separate enable flip-flop decides whether each sync pulse also reaches the CPU as a non-maskable interrupt request. One-cycle strobes set and clear this flip-flop, and it never stops or restarts the counter.

All loads and resets are synchronous, so the decode logic never sees a count that has been only partly reset. A parameter selects a down-counting form. In that form the count runs from 206 down to 0, and the sync and porch windows sit at the matching positions.

Top module: `hsync_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the following clock edge leaves `count` at its restart value (0 counting up, 206 counting down), `hsync`, `back_porch` and `nmi_req` low, and the NMI enable cleared. No NMI request then appears until `nmi_on` is strobed.
- R2: Counting up with no acknowledge, `count` advances by one on each clock. It goes from 206 back to 0, so the line repeats every 207 clocks and the value 207 never appears.
- R3: `hsync` is high exactly while the line position is 16 to 31 inclusive, and it changes on the same edge as `count`.
- R4: `back_porch` is high exactly while the line position is 32 to 47 inclusive. It is never high together with `hsync`.
- R5: An `intack` sampled high at a clock edge puts the counter at line position 0 in the following cycle, whatever the count was before. This takes priority over normal counting and also ends a sync pulse that is in progress.
- R6: A one-cycle `nmi_on` strobe sets the NMI enable. While the enable is set, `nmi_req` follows `hsync` on the same edges.
- R7: A one-cycle `nmi_off` strobe clears the NMI enable, and `nmi_req` is low from the next cycle on. When `nmi_on` and `nmi_off` arrive in the same cycle, the enable ends up cleared.
- R8: The `nmi_on` and `nmi_off` strobes never change the count sequence.
- R9: With `COUNT_DOWN` set to 1, `count` equals 206 minus the line position. It runs from 206 down to 0 and then reloads 206. `hsync` is high for counts 190 down to 175, `back_porch` is high for counts 174 down to 159, and `intack` loads 206.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| intack | input | 1 | CPU interrupt-acknowledge strobe; restarts the line |
| nmi_on | input | 1 | Strobe that sets the NMI enable |
| nmi_off | input | 1 | Strobe that clears the NMI enable; wins over `nmi_on` |
| hsync | output | 1 | Horizontal sync, active high |
| back_porch | output | 1 | High in the window that follows sync |
| nmi_req | output | 1 | Sync passed on as an NMI request while enabled |
| count | output | $clog2(LINE_LEN) | Current counter value |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the default parameters (counting up, 207-clock line, 16-clock windows). The other is the same except that `COUNT_DOWN` is 1. Because both copies share every input, a single line-position model checks the up count, the down count at 206 minus that position, and both sets of window decodes on every clock. This brings the down-count reload, and the matching placement of its sync and porch windows, within reach of the same scenarios that test acknowledge restarts and the enable strobes.

// File: rtl/hsync_gen.sv
module hsync_gen #(
  parameter int LINE_LEN   = 207,
  parameter int SYNC_START = 16,
  parameter int SYNC_LEN   = 16,
  parameter int PORCH_LEN  = 16,
  parameter bit COUNT_DOWN = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        intack,
  input  logic                        nmi_on,
  input  logic                        nmi_off,
  output logic                        hsync,
  output logic                        back_porch,
  output logic                        nmi_req,
  output logic [$clog2(LINE_LEN)-1:0] count
);
  localparam int W         = $clog2(LINE_LEN);
  localparam int LAST      = LINE_LEN - 1;
  localparam int PORCH_BEG = SYNC_START + SYNC_LEN;
  localparam int PORCH_END = PORCH_BEG + PORCH_LEN;
  localparam logic [W-1:0] LAST_V    = W'(LAST);
  localparam logic [W-1:0] RESTART_V = COUNT_DOWN ? LAST_V : '0;

  logic [W-1:0] cnt_q, step, cnt_n, ph_n;
  logic         en_q, en_n, hs_n, bp_n;
  logic         hs_q, bp_q, nmi_q;

  generate
    if (COUNT_DOWN) begin : g_down
      assign step = (cnt_q == '0) ? LAST_V : cnt_q - 1'b1;
      assign ph_n = LAST_V - cnt_n;
    end else begin : g_up
      assign step = (cnt_q == LAST_V) ? '0 : cnt_q + 1'b1;
      assign ph_n = cnt_n;
    end
  endgenerate

  assign cnt_n = intack ? RESTART_V : step;
  assign en_n  = nmi_off ? 1'b0 : (nmi_on ? 1'b1 : en_q);
  assign hs_n  = (ph_n >= W'(SYNC_START)) && (ph_n < W'(PORCH_BEG));
  assign bp_n  = (ph_n >= W'(PORCH_BEG))  && (ph_n < W'(PORCH_END));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RESTART_V;
      en_q  <= 1'b0;
      hs_q  <= 1'b0;
      bp_q  <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      en_q  <= en_n;
      hs_q  <= hs_n;
      bp_q  <= bp_n;
      nmi_q <= hs_n & en_n;
    end
  end

  assign count      = cnt_q;
  assign hsync      = hs_q;
  assign back_porch = bp_q;
  assign nmi_req    = nmi_q;
endmodule

// File: rtl/hsync_gen_chk.sv
module hsync_gen_chk #(
  parameter int LINE_LEN   = 207,
  parameter int SYNC_START = 16,
  parameter int SYNC_LEN   = 16,
  parameter int PORCH_LEN  = 16,
  parameter bit COUNT_DOWN = 1'b0
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        intack,
  input logic                        nmi_off,
  input logic                        hsync,
  input logic                        back_porch,
  input logic                        nmi_req,
  input logic [$clog2(LINE_LEN)-1:0] count
);
  localparam int W = $clog2(LINE_LEN);
  localparam logic [W-1:0] LAST_V = W'(LINE_LEN - 1);
  localparam int PB = SYNC_START + SYNC_LEN;

  logic [W-1:0] ph;
  assign ph = COUNT_DOWN ? LAST_V - count : count;

  always_comb if (!rst) AST_COUNT_RANGE: assert (count <= LAST_V); // R2

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!intack && ph != LAST_V) |=> ph == $past(ph) + W'(1)); // R2
  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!intack && ph == LAST_V) |=> ph == '0); // R9
  AST_ACK_RESTART: assert property (@(posedge clk) disable iff (rst)
    intack |=> ph == '0); // R5
  AST_SYNC_WINDOW: assert property (@(posedge clk) disable iff (rst)
    hsync == (ph >= W'(SYNC_START) && ph < W'(PB))); // R3
  AST_PORCH_APART: assert property (@(posedge clk) disable iff (rst)
    !(hsync && back_porch)); // R4
  AST_NMI_GATED: assert property (@(posedge clk) disable iff (rst)
    nmi_req |-> hsync); // R6
  AST_OFF_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    nmi_off |=> !nmi_req); // R7
endmodule

bind hsync_gen hsync_gen_chk #(
  .LINE_LEN(LINE_LEN), .SYNC_START(SYNC_START), .SYNC_LEN(SYNC_LEN),
  .PORCH_LEN(PORCH_LEN), .COUNT_DOWN(COUNT_DOWN)
) u_chk (
  .clk(clk), .rst(rst), .intack(intack), .nmi_off(nmi_off),
  .hsync(hsync), .back_porch(back_porch), .nmi_req(nmi_req), .count(count)
);

// File: tb/test_hsync_gen.sv
module test_hsync_gen;
  logic clk = 1'b0, rst = 1'b1, intack = 1'b0, nmi_on = 1'b0, nmi_off = 1'b0;
  logic hs_u, bp_u, nmi_u, hs_d, bp_d, nmi_d;
  logic [7:0] cnt_u, cnt_d;
  int checks = 0, errors = 0;
  int m = 0;
  bit en = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hsync_gen i_hsync_gen (.clk(clk), .rst(rst), .intack(intack), .nmi_on(nmi_on),
    .nmi_off(nmi_off), .hsync(hs_u), .back_porch(bp_u), .nmi_req(nmi_u), .count(cnt_u));
  hsync_gen #(.COUNT_DOWN(1'b1)) i_hsync_gen_dn (.clk(clk), .rst(rst), .intack(intack),
    .nmi_on(nmi_on), .nmi_off(nmi_off), .hsync(hs_d), .back_porch(bp_d), .nmi_req(nmi_d),
    .count(cnt_d));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (line pos %0d)", req, what, act, exp, m);
    end
  endtask

  task automatic tick(input string req);
    bit hs, bp;
    @(posedge clk);
    if (rst) begin m = 0; en = 1'b0; end
    else begin
      m  = intack ? 0 : (m == 206 ? 0 : m + 1);
      en = nmi_off ? 1'b0 : (nmi_on ? 1'b1 : en);
    end
    @(negedge clk);
    intack = 1'b0; nmi_on = 1'b0; nmi_off = 1'b0;
    hs = (m >= 16 && m <= 31) && !rst;
    bp = (m >= 32 && m <= 47) && !rst;
    chk(req, "count", int'(cnt_u), m);
    chk(req, "hsync", int'(hs_u), int'(hs));
    chk(req, "back_porch", int'(bp_u), int'(bp));
    chk(req, "nmi_req", int'(nmi_u), int'(hs && en));
    chk("R9", "down count", int'(cnt_d), rst ? 206 : 206 - m);
    chk("R9", "down hsync", int'(hs_d), int'(hs));
    chk("R9", "down back_porch", int'(bp_d), int'(bp));
    chk("R9", "down nmi_req", int'(nmi_d), int'(hs && en));
  endtask

  task automatic run_to(input int pos, input string req);
    while (m != pos) tick(req);
  endtask

  task automatic t_reset();
    rst = 1'b1; nmi_on = 1'b1;
    tick("R1"); tick("R1");
    rst = 1'b0;
    for (int i = 0; i < 60; i++) tick("R1");
  endtask

  task automatic t_free_run();
    for (int i = 0; i < 2 * 207 + 5; i++) tick("R2 R3 R4");
  endtask

  task automatic t_ack();
    run_to(100, "R5");
    intack = 1'b1; tick("R5");
    for (int i = 0; i < 25; i++) tick("R5");
    intack = 1'b1; tick("R5");
    chk("R5", "hsync ended by ack", int'(hs_u), 0);
    run_to(206, "R5");
    intack = 1'b1; tick("R5");
    tick("R5");
  endtask

  task automatic t_nmi_on();
    run_to(5, "R6");
    nmi_on = 1'b1; tick("R6");
    for (int i = 0; i < 60; i++) tick("R6");
  endtask

  task automatic t_nmi_off();
    run_to(20, "R7");
    chk("R7", "nmi before off", int'(nmi_u), 1);
    nmi_off = 1'b1; tick("R7");
    chk("R7", "nmi after off", int'(nmi_u), 0);
    run_to(5, "R7");
    nmi_on = 1'b1; tick("R7");
    nmi_on = 1'b1; nmi_off = 1'b1; tick("R7");
    run_to(40, "R7");
  endtask

  task automatic t_strobes_keep_count();
    run_to(204, "R8");
    nmi_on = 1'b1; tick("R8");
    nmi_off = 1'b1; tick("R8");
    nmi_on = 1'b1; nmi_off = 1'b1; tick("R8");
    nmi_on = 1'b1; tick("R8");
    for (int i = 0; i < 20; i++) tick("R8");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_free_run();
    t_ack();
    t_nmi_on();
    t_nmi_off();
    t_strobes_keep_count();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule